// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a two-port memory and watches the access strobes and addresses of both ports. It keeps one interrupt flag for each port, and it uses the two highest addresses of the space as mailboxes. Port A owns the mailbox at the next-to-top address. Port B owns the mailbox at the top address.

When one port writes the mailbox that belongs to the other port, the other port's interrupt output goes active (low). The receiving port drops its own interrupt by reading its own mailbox. The message byte itself stays in the ordinary memory array, and this block does not hold it.

An enable input turns the mailbox behaviour on or off. While the enable is low, the two top addresses behave as ordinary storage and have no interrupt side effects.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after reset has been released, both `a_irq_n` and `b_irq_n` are high (1 = no interrupt). Port A's mailbox is address 2^ADDR_W-2 (0x1FFE at the default width). Port B's mailbox is address 2^ADDR_W-1 (0x1FFF).
- R2: Port B writes 0x1FFE while `mbox_en`=1 (`b_sel_n`=0 and `b_wr_n`=0). After the next rising clock edge, `a_irq_n` is 0, and it stays 0 until a clear.
- R3: Port A reads 0x1FFE while `mbox_en`=1 (`a_sel_n`=0 and `a_oe_n`=0, with `a_wr_n` at either level). After the next rising edge, `a_irq_n` is 1.
- R4: Port A writes 0x1FFF while `mbox_en`=1. After the next rising edge, `b_irq_n` is 0.
- R5: Port B reads 0x1FFF while `mbox_en`=1 (`b_sel_n`=0 and `b_oe_n`=0). After the next rising edge, `b_irq_n` is 1.
- R6: A write counts only when select and write strobe are both low. A read counts only when select and output enable are both low. A strobe without select changes neither flag.
- R7: While `mbox_en`=0, no access sets or clears either flag, and both outputs hold their values.
- R8: If a set and a clear of the same flag occur in the same cycle, the flag ends up set.
- R9: A port writing its own mailbox with its output enable high leaves its own flag unchanged. A port reading the other port's mailbox leaves both flags unchanged.
- R10: Accesses to any address other than the two mailboxes leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mbox_en | input | 1 | 1 = mailbox interrupts enabled |
| a_sel_n | input | 1 | Port A select, active low |
| a_wr_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A address |
| b_sel_n | input | 1 | Port B select, active low |
| b_wr_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B address |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The directed patterns work through the following cases:
- Cross-port writes, compared with same-port writes, show that each flag is set only by the opposite port.
- Reads of a port's own mailbox, compared with reads of the other port's mailbox, show that only the owner clears.
- A read with the write strobe also low confirms that the write line does not matter for a clear.
- Strobes with select high, accesses to neighbouring addresses, and accesses with the enable low each separate a real mailbox hit from something that only looks like one.
- Simultaneous set and clear of one flag exposes the priority.

A pseudo-random mix over the mailbox and neighbouring addresses is then compared cycle by cycle against a behavioural model. A reset in the middle of the run, with both flags set, shows that both flags return to inactive.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

  // Decoded mailbox hits for one port.
  // Bit index 0 of each field refers to port A's box and index 1 to port B's box.
  typedef struct packed {
    logic [1:0] wr_box;
    logic [1:0] rd_box;
  } mbox_hits_t;

  localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
  import mbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              en,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output mbox_hits_t        hits
);

  localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_A = BOX_B - 1'b1;

  logic       wr_act;
  logic       rd_act;
  logic [1:0] addr_hit;

  always_comb begin
    wr_act      = en && !sel_n && !wr_n;
    rd_act      = en && !sel_n && !oe_n;
    addr_hit[0] = (addr == BOX_A);
    addr_hit[1] = (addr == BOX_B);
    hits.wr_box = addr_hit & {2{wr_act}};
    hits.rd_box = addr_hit & {2{rd_act}};
  end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic active
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set || clr;
    flag_d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign active = flag_q;

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              a_sel_n,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_sel_n,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              a_irq_n,
  output logic              b_irq_n
);

  logic                    rst_int_n;
  logic [NUM_PORTS-1:0]    sel_n_v;
  logic [NUM_PORTS-1:0]    wr_n_v;
  logic [NUM_PORTS-1:0]    oe_n_v;
  logic [ADDR_W-1:0]       addr_v [NUM_PORTS];
  mbox_hits_t              hits_v [NUM_PORTS];
  logic [NUM_PORTS-1:0]    set_v;
  logic [NUM_PORTS-1:0]    clr_v;
  logic [NUM_PORTS-1:0]    act_v;

  mbox_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    sel_n_v   = {b_sel_n, a_sel_n};
    wr_n_v    = {b_wr_n, a_wr_n};
    oe_n_v    = {b_oe_n, a_oe_n};
    addr_v[0] = a_addr;
    addr_v[1] = b_addr;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbox_port_decode #(.ADDR_W(ADDR_W)) u_dec (
      .en    (mbox_en),
      .sel_n (sel_n_v[p]),
      .wr_n  (wr_n_v[p]),
      .oe_n  (oe_n_v[p]),
      .addr  (addr_v[p]),
      .hits  (hits_v[p])
    );

    // A flag is raised by the opposite port writing this port's box,
    // and dropped by this port reading its own box.
    always_comb begin
      set_v[p] = hits_v[NUM_PORTS-1-p].wr_box[p];
      clr_v[p] = hits_v[p].rd_box[p];
    end

    mbox_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set    (set_v[p]),
      .clr    (clr_v[p]),
      .active (act_v[p])
    );
  end

  assign a_irq_n = ~act_v[0];
  assign b_irq_n = ~act_v[1];

endmodule

// File: rtl/mbox_irq_ctrl_chk.sv
module mbox_irq_ctrl_chk #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbox_en,
  input logic              a_sel_n,
  input logic              a_wr_n,
  input logic              a_oe_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_sel_n,
  input logic              b_wr_n,
  input logic              b_oe_n,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_irq_n,
  input logic              b_irq_n
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] NXT = TOP - 1'b1;

  logic a_up, a_dn, b_up, b_dn;
  assign a_up = mbox_en && !b_sel_n && !b_wr_n && (b_addr == NXT);
  assign a_dn = mbox_en && !a_sel_n && !a_oe_n && (a_addr == NXT);
  assign b_up = mbox_en && !a_sel_n && !a_wr_n && (a_addr == TOP);
  assign b_dn = mbox_en && !b_sel_n && !b_oe_n && (b_addr == TOP);

  // R2, R8: a write to port A's box by port B wins
  a_r2_a_set: assert property (@(posedge clk) disable iff (!rst_n)
    a_up |=> !a_irq_n);
  // R3
  a_r3_a_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (a_dn && !a_up) |=> a_irq_n);
  // R4, R8
  a_r4_b_set: assert property (@(posedge clk) disable iff (!rst_n)
    b_up |=> !b_irq_n);
  // R5
  a_r5_b_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (b_dn && !b_up) |=> b_irq_n);
  // R7
  a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> ($stable(a_irq_n) && $stable(b_irq_n)));
  // R10, R6, R9: without a qualifying event a flag holds
  a_r10_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_up || a_dn) |=> $stable(a_irq_n));
  a_r10_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_up || b_dn) |=> $stable(b_irq_n));

endmodule

bind mbox_irq_ctrl mbox_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mbox_en (mbox_en),
  .a_sel_n (a_sel_n),
  .a_wr_n  (a_wr_n),
  .a_oe_n  (a_oe_n),
  .a_addr  (a_addr),
  .b_sel_n (b_sel_n),
  .b_wr_n  (b_wr_n),
  .b_oe_n  (b_oe_n),
  .b_addr  (b_addr),
  .a_irq_n (a_irq_n),
  .b_irq_n (b_irq_n)
);

// File: tb/mbox_irq_ctrl_test.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_test;

  localparam int AW = 13;
  localparam logic [AW-1:0] BOXA = 13'h1FFE;
  localparam logic [AW-1:0] BOXB = 13'h1FFF;

  logic clk = 1'b0;
  logic rst_n;
  logic mbox_en;
  logic a_sel_n, a_wr_n, a_oe_n, b_sel_n, b_wr_n, b_oe_n;
  logic [AW-1:0] a_addr, b_addr;
  logic a_irq_n, b_irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_a  = 0;   // 1 = interrupt expected active
  bit exp_b  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  mbox_irq_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .a_sel_n(a_sel_n), .a_wr_n(a_wr_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .b_sel_n(b_sel_n), .b_wr_n(b_wr_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
  );

  task automatic compare(input string tag);
    checks++;
    if (a_irq_n !== ~exp_a) begin
      fails++;
      $display("FAIL %s a_irq_n actual=%b expected=%b t=%0t", tag, a_irq_n, ~exp_a, $time);
    end
    checks++;
    if (b_irq_n !== ~exp_b) begin
      fails++;
      $display("FAIL %s b_irq_n actual=%b expected=%b t=%0t", tag, b_irq_n, ~exp_b, $time);
    end
  endtask

  // Called at a falling edge: apply inputs, advance the model, compare after the edge.
  task automatic step(input string tag, input logic en,
                      input logic as, input logic aw, input logic ao, input logic [AW-1:0] aa,
                      input logic bs, input logic bw, input logic bo, input logic [AW-1:0] ba);
    bit a_raise, a_drop, b_raise, b_drop;
    mbox_en = en;
    a_sel_n = as; a_wr_n = aw; a_oe_n = ao; a_addr = aa;
    b_sel_n = bs; b_wr_n = bw; b_oe_n = bo; b_addr = ba;
    a_raise = en && (bs == 0) && (bw == 0) && (ba == BOXA);
    a_drop  = en && (as == 0) && (ao == 0) && (aa == BOXA);
    b_raise = en && (as == 0) && (aw == 0) && (aa == BOXB);
    b_drop  = en && (bs == 0) && (bo == 0) && (ba == BOXB);
    if (a_raise) exp_a = 1; else if (a_drop) exp_a = 0;
    if (b_raise) exp_b = 1; else if (b_drop) exp_b = 0;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1, 1, 1, 1, 13'h0, 1, 1, 1, 13'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    exp_a = 0; exp_b = 0;
    repeat (3) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1'b1;
    repeat (4) idle("R1");
  endtask

  initial begin
    rst_n = 1'b0;
    mbox_en = 1'b1;
    a_sel_n = 1; a_wr_n = 1; a_oe_n = 1; a_addr = '0;
    b_sel_n = 1; b_wr_n = 1; b_oe_n = 1; b_addr = '0;
    do_reset();

    // R6: write strobe without select
    step("R6", 1, 1, 1, 1, 13'h0, 1, 0, 1, BOXA);
    // R2: B writes A's box
    step("R2", 1, 1, 1, 1, 13'h0, 0, 0, 1, BOXA);
    idle("R2");
    idle("R10");
    // R9: A writes its own box, A reads B's box
    step("R9", 1, 0, 0, 1, BOXA, 1, 1, 1, 13'h0);
    step("R9", 1, 0, 1, 0, BOXB, 1, 1, 1, 13'h0);
    // R6: read enable without select does not clear
    step("R6", 1, 1, 1, 0, BOXA, 1, 1, 1, 13'h0);
    // R3: A reads its box with write line low too
    step("R3", 1, 0, 0, 0, BOXA, 1, 1, 1, 13'h0);
    // R4: A writes B's box
    step("R4", 1, 0, 0, 1, BOXB, 1, 1, 1, 13'h0);
    // R7: disabled, B reads its box and B writes A's box
    step("R7", 0, 1, 1, 1, 13'h0, 0, 1, 0, BOXB);
    step("R7", 0, 1, 1, 1, 13'h0, 0, 0, 1, BOXA);
    // R9: B writes its own box
    step("R9", 1, 1, 1, 1, 13'h0, 0, 0, 1, BOXB);
    // R5: B reads its box
    step("R5", 1, 1, 1, 1, 13'h0, 0, 1, 0, BOXB);
    // R8: set and clear of A together
    step("R8", 1, 0, 1, 0, BOXA, 0, 0, 1, BOXA);
    step("R3", 1, 0, 1, 0, BOXA, 1, 1, 1, 13'h0);
    // R8: set and clear of B together
    step("R8", 1, 0, 0, 1, BOXB, 0, 1, 0, BOXB);
    // R10: neighbouring addresses
    step("R10", 1, 0, 0, 1, 13'h1FFD, 0, 0, 1, 13'h0000);
    step("R10", 1, 0, 1, 0, 13'h0FFF, 0, 1, 0, 13'h1FFD);
    step("R5", 1, 1, 1, 1, 13'h0, 0, 1, 0, BOXB);
    // R7: disabled set attempt on B
    step("R7", 0, 0, 0, 1, BOXB, 1, 1, 1, 13'h0);

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] pa, pb;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: pa = BOXA; 2'd1: pa = BOXB; 2'd2: pa = 13'h1FFD; default: pa = 13'h0004;
      endcase
      case (lfsr[3:2])
        2'd0: pb = BOXB; 2'd1: pb = BOXA; 2'd2: pb = 13'h1FFC; default: pb = 13'h1FFE;
      endcase
      step("R8", (lfsr[15:13] != 3'b000), lfsr[4] & lfsr[11], lfsr[5], lfsr[6], pa,
           lfsr[7] & lfsr[12], lfsr[8], lfsr[9], pb);
    end

    // R1: reset with both flags active
    step("R2", 1, 1, 1, 1, 13'h0, 0, 0, 1, BOXA);
    step("R4", 1, 0, 0, 1, BOXB, 1, 1, 1, 13'h0);
    do_reset();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule